// File: doc/BRIEF.md
# Charge Pump Power Sequencer

This block is the digital controller of a two-rail charge pump supply with one positive and one negative output. It runs from the internal pump clock. When the enable input rises, it starts the pump and the positive regulator. It starts the negative regulator only after the positive-rail monitor reports that the rail has crossed its threshold. After a programmable blanking window from pump start, an over-current flag is acted on. A trip turns both regulators off and latches a fault.

Every shutdown passes through a timed drain phase. This happens whether the cause is enable falling or a protection trip. In the drain phase the regulators are off but the pump keeps running for a programmable number of cycles. A latched fault holds the supply off until enable has been seen low. No other input clears it. All windows are counted in clock cycles and set by parameters. The defaults are 36,000 cycles of blanking and 11,200 cycles of drain, both at 2 MHz.

Top module: `cp_sequencer`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, all four outputs are low.
- R2: Suppose `enable` is sampled high in the idle state. In the next cycle `pumpRun` and `posRegEn` are high and `negRegEn` is low. Cycle index 0 is the first cycle in which `pumpRun` is high.
- R3: `negRegEn` rises exactly one cycle after the first cycle in which `posGood` is sampled high during start-up, and never earlier.
- R4: `overCurrent` sampled in a start-up or running cycle whose index is below MASK_CYC has no effect. The regulators stay on and `faultFlag` stays low.
- R5: Suppose `overCurrent` is sampled high in a start-up or running cycle whose index is MASK_CYC or more. The next cycle has both regulator enables low and `faultFlag` high. `pumpRun` then stays high for exactly HOLD_CYC cycles and is low afterwards.
- R6: Suppose `enable` is sampled low during start-up or running. Both regulator enables drop in the next cycle. `pumpRun` stays high for exactly HOLD_CYC cycles, then all outputs are low, with `faultFlag` low throughout.
- R7: If `enable` returns high during the drain phase, the drain is not shortened. One idle cycle with `pumpRun` low follows, and start-up begins in the cycle after it.
- R8: `overCurrent` during the drain phase is ignored. `faultFlag` stays low after a drain caused by `enable`.
- R9: After a fault drain, `faultFlag` stays high with all drives low for as long as `enable` is high, whatever `posGood` and `overCurrent` do. `enable` sampled low clears `faultFlag` in the next cycle, and a later rise of `enable` starts the supply again.
- R10: If an unmasked over-current and a low `enable` are sampled in the same cycle, the protection path wins and `faultFlag` is set.
- R11: `negRegEn` is never high without `posRegEn`, and no regulator enable is high without `pumpRun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal pump-domain clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Supply enable, active high |
| posGood | input | 1 | Positive rail above its monitor threshold |
| overCurrent | input | 1 | Short-circuit / over-current flag from either output |
| pumpRun | output | 1 | Charge pump switching enable |
| posRegEn | output | 1 | Positive regulator enable |
| negRegEn | output | 1 | Negative regulator enable |
| faultFlag | output | 1 | Protection trip latched |

## Verification
The properties assume that `enable`, `posGood` and `overCurrent` are already synchronous to `clk`, since the comparators and any synchronisers sit outside this block. They also assume MASK_CYC and HOLD_CYC are at least one. The bench changes these inputs only just after a rising edge, so each value is held for a whole cycle. It uses a small blanking window and a short drain so that the sweeps can place a trip, a rail-good report or an enable drop in every cycle around each window boundary. Over-current pulses last one cycle, so the blanking boundary is crossed in both directions within the sweep.

// File: rtl/cp_seq_pkg.sv
package cp_seq_pkg;

  typedef enum logic [2:0] {
    seqIdle      = 3'd0,
    seqRaisePos  = 3'd1,
    seqRaiseNeg  = 3'd2,
    seqSteady    = 3'd3,
    seqDrain     = 3'd4,
    seqLatched   = 3'd5
  } seqState_t;

  typedef struct packed {
    logic clrCnt;
    logic cntEn;
  } seqStrobe_t;

endpackage

// File: rtl/cp_seq_timer.sv
module cp_seq_timer #(
  parameter int MASK_CYC = 36000,
  parameter int HOLD_CYC = 11200
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  cp_seq_pkg::seqStrobe_t  strobe,
  output logic                    maskDone,
  output logic                    holdDone
);

  localparam int MAX_CYC = (MASK_CYC > HOLD_CYC) ? MASK_CYC : HOLD_CYC;
  localparam int CW = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] MASK_V    = CW'(MASK_CYC);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] SAT_V     = '1;

  logic [CW-1:0] cnt;

  // Counts cycles since the last clear; saturates so long runs stay unmasked.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.clrCnt) begin
      cnt <= '0;
    end else if (strobe.cntEn && (cnt != SAT_V)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign maskDone = (cnt >= MASK_V);
  assign holdDone = (cnt == HOLD_LAST);

endmodule

// File: rtl/cp_seq_ctrl.sv
module cp_seq_ctrl (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic                    posGood,
  input  logic                    overCurrent,
  input  logic                    maskDone,
  input  logic                    holdDone,
  output cp_seq_pkg::seqStrobe_t  strobe,
  output logic                    pumpRun,
  output logic                    posRegEn,
  output logic                    negRegEn,
  output logic                    faultFlag
);
  import cp_seq_pkg::*;

  seqState_t state, stateNxt;
  logic      faultReg, faultNxt;
  logic      active;
  logic      trip;

  assign active = (state == seqRaisePos) || (state == seqRaiseNeg) || (state == seqSteady);
  assign trip   = active && maskDone && overCurrent;

  always_comb begin
    stateNxt      = state;
    faultNxt      = faultReg;
    strobe.clrCnt = 1'b0;
    strobe.cntEn  = (state != seqIdle) && (state != seqLatched);
    unique case (state)
      seqIdle: begin
        if (enable) begin
          stateNxt      = seqRaisePos;
          strobe.clrCnt = 1'b1;
        end
      end
      seqRaisePos, seqRaiseNeg, seqSteady: begin
        if (trip) begin
          // protection has priority over a simultaneous enable drop
          stateNxt      = seqDrain;
          faultNxt      = 1'b1;
          strobe.clrCnt = 1'b1;
        end else if (!enable) begin
          stateNxt      = seqDrain;
          strobe.clrCnt = 1'b1;
        end else if ((state == seqRaisePos) && posGood) begin
          stateNxt = seqRaiseNeg;
        end else if ((state == seqRaiseNeg) && maskDone) begin
          stateNxt = seqSteady;
        end
      end
      seqDrain: begin
        if (holdDone) begin
          stateNxt = faultReg ? seqLatched : seqIdle;
        end
      end
      seqLatched: begin
        if (!enable) begin
          stateNxt = seqIdle;
          faultNxt = 1'b0;
        end
      end
      default: begin
        stateNxt = seqIdle;
        faultNxt = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= seqIdle;
      faultReg <= 1'b0;
    end else begin
      state    <= stateNxt;
      faultReg <= faultNxt;
    end
  end

  assign pumpRun   = active || (state == seqDrain);
  assign posRegEn  = active;
  assign negRegEn  = (state == seqRaiseNeg) || (state == seqSteady);
  assign faultFlag = faultReg;

endmodule

// File: rtl/cp_sequencer.sv
module cp_sequencer #(
  parameter int MASK_CYC = 36000,
  parameter int HOLD_CYC = 11200
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic posGood,
  input  logic overCurrent,
  output logic pumpRun,
  output logic posRegEn,
  output logic negRegEn,
  output logic faultFlag
);

  cp_seq_pkg::seqStrobe_t strobe;
  logic maskDone;
  logic holdDone;

  cp_seq_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .posGood     (posGood),
    .overCurrent (overCurrent),
    .maskDone    (maskDone),
    .holdDone    (holdDone),
    .strobe      (strobe),
    .pumpRun     (pumpRun),
    .posRegEn    (posRegEn),
    .negRegEn    (negRegEn),
    .faultFlag   (faultFlag)
  );

  cp_seq_timer #(
    .MASK_CYC (MASK_CYC),
    .HOLD_CYC (HOLD_CYC)
  ) uTimer (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .maskDone (maskDone),
    .holdDone (holdDone)
  );

endmodule

// File: rtl/cp_sequencer_chk.sv
module cp_sequencer_chk #(
  parameter int MASK_CYC = 36000,
  parameter int HOLD_CYC = 11200
) (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic posGood,
  input logic overCurrent,
  input logic pumpRun,
  input logic posRegEn,
  input logic negRegEn,
  input logic faultFlag
);

  logic [31:0] runIdx;
  logic [31:0] drainIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runIdx   <= '0;
      drainIdx <= '0;
    end else begin
      if (!pumpRun)                   runIdx <= '0;
      else if (runIdx != 32'hFFFF_FFFF) runIdx <= runIdx + 1;
      if (!(pumpRun && !posRegEn))    drainIdx <= '0;
      else                            drainIdx <= drainIdx + 1;
    end
  end

  p_neg_needs_pos_r11: assert property (@(posedge clk) disable iff (!rstN)
    negRegEn |-> posRegEn);

  p_reg_needs_pump_r11: assert property (@(posedge clk) disable iff (!rstN)
    posRegEn |-> pumpRun);

  p_neg_after_good_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(negRegEn) |-> $past(posGood));

  p_blanked_trip_r4: assert property (@(posedge clk) disable iff (!rstN)
    (posRegEn && enable && overCurrent && (runIdx < 32'(MASK_CYC))) |=> !faultFlag);

  p_trip_r5: assert property (@(posedge clk) disable iff (!rstN)
    (posRegEn && overCurrent && (runIdx >= 32'(MASK_CYC))) |=> (faultFlag && pumpRun && !posRegEn));

  p_drain_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pumpRun && !posRegEn) |-> (drainIdx < 32'(HOLD_CYC)));

  p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (faultFlag && !pumpRun && enable) |=> (faultFlag && !pumpRun));

  p_latch_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (faultFlag && !pumpRun && !enable) |=> !faultFlag);

endmodule

bind cp_sequencer cp_sequencer_chk #(
  .MASK_CYC (MASK_CYC),
  .HOLD_CYC (HOLD_CYC)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .enable      (enable),
  .posGood     (posGood),
  .overCurrent (overCurrent),
  .pumpRun     (pumpRun),
  .posRegEn    (posRegEn),
  .negRegEn    (negRegEn),
  .faultFlag   (faultFlag)
);

// File: tb/sim_cp_sequencer.sv
module sim_cp_sequencer;

  localparam int MASK = 6;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic posGood = 1'b0;
  logic overCurrent = 1'b0;
  logic pumpRun, posRegEn, negRegEn, faultFlag;

  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cp_sequencer #(.MASK_CYC(MASK), .HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .posGood(posGood),
    .overCurrent(overCurrent), .pumpRun(pumpRun), .posRegEn(posRegEn),
    .negRegEn(negRegEn), .faultFlag(faultFlag)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // expected order: {pumpRun, posRegEn, negRegEn, faultFlag}
  task automatic check(string req, logic [3:0] exp);
    logic [3:0] act;
    act = {pumpRun, posRegEn, negRegEn, faultFlag};
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t act=%b exp=%b", req, $time, act, exp);
    end
  endtask

  task automatic goIdle();
    enable = 1'b0; posGood = 1'b0; overCurrent = 1'b0;
    for (int k = 0; k < HOLD + 3; k++) step();
  endtask

  initial begin
    #3;
    check("R1", 4'b0000);
    step(); step();
    check("R1", 4'b0000);
    rstN = 1'b1;
    step();
    check("R1", 4'b0000);

    // R2 / R3: rail-good report at every delay d
    for (int d = 0; d < 8; d++) begin
      goIdle();
      check("R2", 4'b0000);
      enable = 1'b1;
      for (int k = 1; k <= 14; k++) begin
        int i;
        step();
        i = k - 1;
        check((i == 0) ? "R2" : "R3", {1'b1, 1'b1, (i >= d + 1), 1'b0});
        posGood = (i >= d);
      end
    end

    // R4 / R5 / R9: one-cycle over-current at every index j
    for (int j = 0; j < 12; j++) begin
      bit tripped;
      tripped = (j >= MASK);
      goIdle();
      enable = 1'b1; posGood = 1'b1;
      for (int k = 1; k <= j + HOLD + 4; k++) begin
        int i;
        logic [3:0] exp;
        step();
        i = k - 1;
        if (!tripped || i <= j) exp = {1'b1, 1'b1, (i >= 1), 1'b0};
        else if (i <= j + HOLD) exp = 4'b1001;
        else                    exp = 4'b0001;
        check(tripped ? "R5" : "R4", exp);
        overCurrent = (i == j);
      end
      if (tripped) begin
        for (int k = 0; k < 5; k++) begin
          posGood = k[0]; overCurrent = ~k[0];
          step();
          check("R9", 4'b0001);
        end
        enable = 1'b0; overCurrent = 1'b0; posGood = 1'b1;
        step();
        check("R9", 4'b0000);
        enable = 1'b1;
        step();
        check("R9", 4'b1100);
      end
    end

    // R6 / R7 / R8: enable drop at index j, optional re-raise in drain
    for (int r = 0; r < 2; r++) begin
      for (int j = 0; j < 6; j++) begin
        goIdle();
        enable = 1'b1; posGood = 1'b1;
        for (int k = 1; k <= j + HOLD + 6; k++) begin
          int i;
          logic [3:0] exp;
          step();
          i = k - 1;
          if (i <= j)                 exp = {1'b1, 1'b1, (i >= 1), 1'b0};
          else if (i <= j + HOLD)     exp = 4'b1000;
          else if (i == j + HOLD + 1) exp = 4'b0000;
          else if (r == 1)            exp = {1'b1, 1'b1, (i >= j + HOLD + 3), 1'b0};
          else                        exp = 4'b0000;
          check((i > j + HOLD) ? ((r == 1) ? "R7" : "R6") : ((i > j) ? "R8" : "R6"), exp);
          enable      = (i < j) || ((r == 1) && (i >= j + 2));
          overCurrent = (i == j + 2);
        end
      end
    end

    // R10: unmasked trip together with enable drop
    goIdle();
    enable = 1'b1; posGood = 1'b1;
    for (int k = 1; k <= MASK + 3 + HOLD + 3; k++) begin
      int i;
      int t;
      logic [3:0] exp;
      step();
      i = k - 1;
      t = MASK + 2;
      if (i <= t)                 exp = {1'b1, 1'b1, (i >= 1), 1'b0};
      else if (i <= t + HOLD)     exp = 4'b1001;
      else if (i == t + HOLD + 1) exp = 4'b0001;
      else                        exp = 4'b0000;
      check("R10", exp);
      enable      = (i < t);
      overCurrent = (i == t);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule